// File: doc/BRIEF.md
# FSM Checking-Experiment Sequencer

This block is a built-in self-test controller for a small synchronous Mealy machine. The machine has four states, one input bit and one output bit. The controller drives the machine's input one symbol per clock and reads the machine's output bit in the same cycle. It runs a complete checking experiment in three ordered phases. First it brings the machine from an unknown state to a known start state. Then it makes every state show its response to a two-symbol distinguishing sequence. Finally it takes every one of the eight transitions, and a distinguishing sequence confirms each one.

Initialization applies the sequence 0,1. This sequence is both homing and distinguishing for the reference machine. The controller decodes the final state from the two response bits and, if needed, applies the shortest transfer to the start state A. A fixed 38-symbol check sequence from A follows. Its expected outputs come from the reference state table when the design is elaborated. The result is only a verdict, pass or fail, together with the number of symbols applied. No attempt is made to locate the fault.

Controller states: `C_IDLE` (waiting), `C_HOME0` (drive 0, capture response), `C_HOME1` (drive 1, decode, choose transfer), `C_XFER` (drive transfer symbols, compare), `C_CHECK` (drive the check sequence, compare). Transitions: IDLE→HOME0 on an accepted start; HOME0→HOME1 always; HOME1→XFER if a transfer is needed, else HOME1→CHECK; XFER→CHECK after the last transfer symbol; CHECK→IDLE after symbol 37, with a done pulse.

Top module: `fsm_check_seq`

## Requirements
- R1: After reset busy_o, done_o, pass_o and fail_o are low and sym_cnt_o is 0.
- R2: The first two symbols after an accepted start are 0 then 1, and their responses are not compared. A response pair (first,second) of (1,0) or (0,0) decodes to final state C, and (0,1) or (1,1) decodes to final state D.
- R3: The transfer to A is 0,0 from C and 1 from D. The expected response of each transfer symbol is 0, and it is compared.
- R4: The reference table, as state, input → next/output, is: A,0→B/1; A,1→D/1; B,0→A/0; B,1→C/0; C,0→B/0; C,1→D/1; D,0→C/1; D,1→A/0. From A the controller applies a fixed 38-symbol sequence that first identifies every state and then takes all eight transitions. Each response is compared against the table in the cycle its symbol is driven.
- R5: Any compared mismatch sets fail_o. fail_o stays high until the next accepted start.
- R6: done_o is high for exactly one cycle, in the cycle after the last symbol. From then on exactly one of pass_o and fail_o is high, and pass_o is high only when no mismatch occurred.
- R7: sym_cnt_o counts every applied symbol. A correct machine gives 42 when started in A or C, and 41 when started in B or D.
- R8: A start asserted while busy_o is high is ignored. The run and its length are unchanged.
- R9: An accepted start clears pass_o, fail_o and sym_cnt_o. busy_o is high from the next cycle until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an experiment (accepted only when idle) |
| stim_o | output | 1 | Input symbol driven to the machine under test |
| resp_i | input | 1 | Output bit of the machine under test, same cycle |
| busy_o | output | 1 | Experiment in progress |
| done_o | output | 1 | One-cycle pulse after the last symbol |
| pass_o | output | 1 | Machine judged correct |
| fail_o | output | 1 | Sticky mismatch flag |
| sym_cnt_o | output | CNT_W | Number of symbols applied |

## Verification
The bench models a correct machine and machines with one faulty output or one misdirected next state. It starts them from every state, so each homing decode and each transfer length is hit. A design that decodes the homing response wrongly, or picks the wrong transfer, would report a correct machine as failing or give the wrong length. One output fault sits on a transition that the homing sequence uses. A controller that compared homing responses, or that skipped the transfer check, would miss that fault or flag a correct machine. Further runs pulse start in the middle of a run and restart after a failed run. These catch a controller that restarts, one that lets fail lapse, and one that keeps a stale verdict or count.

// File: rtl/fce_pkg.sv
package fce_pkg;

    typedef enum logic [1:0] {ST_A, ST_B, ST_C, ST_D} mstate_t;

    typedef enum logic [2:0] {
        C_IDLE,
        C_HOME0,
        C_HOME1,
        C_XFER,
        C_CHECK
    } ctl_t;

    localparam int SEQ_LEN = 38;
    localparam int IDX_W   = $clog2(SEQ_LEN);

    // leftmost bit is applied first: identification (9) then transitions (29)
    localparam logic [0:SEQ_LEN-1] SEQ_BITS =
        38'b010100101_001_001_101_101_1001_1101_00001_0101;

    function automatic mstate_t ref_next(input mstate_t s, input logic x);
        mstate_t n;
        unique case (s)
            ST_A:    n = x ? ST_D : ST_B;
            ST_B:    n = x ? ST_C : ST_A;
            ST_C:    n = x ? ST_D : ST_B;
            default: n = x ? ST_A : ST_C;
        endcase
        return n;
    endfunction

    function automatic logic ref_out(input mstate_t s, input logic x);
        logic o;
        unique case (s)
            ST_A:    o = 1'b1;
            ST_B:    o = 1'b0;
            ST_C:    o = x;
            default: o = ~x;
        endcase
        return o;
    endfunction

    function automatic logic [0:SEQ_LEN-1] calc_exp();
        logic [0:SEQ_LEN-1] e;
        mstate_t s;
        e = '0;
        s = ST_A;
        for (int i = 0; i < SEQ_LEN; i++) begin
            e[i] = ref_out(s, SEQ_BITS[i]);
            s    = ref_next(s, SEQ_BITS[i]);
        end
        return e;
    endfunction

endpackage

// File: rtl/fce_plan.sv
module fce_plan
    import fce_pkg::*;
(
    input  logic       first_i,
    input  logic       second_i,
    output logic [1:0] len_o,
    output logic [1:0] bits_o,
    output logic [1:0] exp_o
);
    mstate_t end_st;

    always_comb begin
        end_st = ST_A;
        for (int s = 0; s < 4; s++) begin
            if ({ref_out(mstate_t'(s), 1'b0),
                 ref_out(ref_next(mstate_t'(s), 1'b0), 1'b1)} == {first_i, second_i})
                end_st = ref_next(ref_next(mstate_t'(s), 1'b0), 1'b1);
        end
    end

    always_comb begin
        len_o  = 2'd0;
        bits_o = 2'b00;
        exp_o  = 2'b00;
        unique case (end_st)
            ST_A: len_o = 2'd0;
            ST_B: begin
                len_o    = 2'd1;
                bits_o   = 2'b00;
                exp_o[0] = ref_out(ST_B, 1'b0);
            end
            ST_C: begin
                len_o    = 2'd2;
                bits_o   = 2'b00;
                exp_o[0] = ref_out(ST_C, 1'b0);
                exp_o[1] = ref_out(ST_B, 1'b0);
            end
            default: begin
                len_o    = 2'd1;
                bits_o   = 2'b01;
                exp_o[0] = ref_out(ST_D, 1'b1);
            end
        endcase
    end
endmodule

// File: rtl/fce_rom.sv
module fce_rom
    import fce_pkg::*;
(
    input  logic [IDX_W-1:0] idx_i,
    output logic             sym_o,
    output logic             exp_o
);
    localparam logic [0:SEQ_LEN-1] EXP_BITS = calc_exp();

    always_comb begin
        sym_o = 1'b0;
        exp_o = 1'b0;
        if (int'(idx_i) < SEQ_LEN) begin
            sym_o = SEQ_BITS[idx_i];
            exp_o = EXP_BITS[idx_i];
        end
    end
endmodule

// File: rtl/fsm_check_seq.sv
module fsm_check_seq
    import fce_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             stim_o,
    input  logic             resp_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             pass_o,
    output logic             fail_o,
    output logic [CNT_W-1:0] sym_cnt_o
);
    ctl_t             state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             xidx_q;
    logic [1:0]       xlen_q, xbits_q, xexp_q;
    logic             h0_q;
    logic [1:0]       plan_len, plan_bits, plan_exp;
    logic             rom_sym, rom_exp;
    logic             exp_bit, cmp_en, mismatch;
    logic             last_chk, last_xfer, start_ok;

    fce_plan plan_i (
        .first_i (h0_q),
        .second_i(resp_i),
        .len_o   (plan_len),
        .bits_o  (plan_bits),
        .exp_o   (plan_exp)
    );

    fce_rom rom_i (
        .idx_i(idx_q),
        .sym_o(rom_sym),
        .exp_o(rom_exp)
    );

    assign start_ok  = (state_q == C_IDLE) && start_i;
    assign last_chk  = (int'(idx_q) == SEQ_LEN - 1);
    assign last_xfer = ({1'b0, xidx_q} == (xlen_q - 2'd1));
    assign busy_o    = (state_q != C_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_IDLE:  if (start_i) state_d = C_HOME0;
            C_HOME0: state_d = C_HOME1;
            C_HOME1: state_d = (plan_len != 2'd0) ? C_XFER : C_CHECK;
            C_XFER:  if (last_xfer) state_d = C_CHECK;
            C_CHECK: if (last_chk) state_d = C_IDLE;
            default: state_d = C_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= C_IDLE;
        else        state_q <= state_d;
    end

    // symbol and expected response of the current cycle
    always_comb begin
        stim_o  = 1'b0;
        exp_bit = 1'b0;
        cmp_en  = 1'b0;
        unique case (state_q)
            C_HOME0: stim_o = 1'b0;
            C_HOME1: stim_o = 1'b1;
            C_XFER: begin
                stim_o  = xbits_q[xidx_q];
                exp_bit = xexp_q[xidx_q];
                cmp_en  = 1'b1;
            end
            C_CHECK: begin
                stim_o  = rom_sym;
                exp_bit = rom_exp;
                cmp_en  = 1'b1;
            end
            default: stim_o = 1'b0;
        endcase
    end

    assign mismatch = cmp_en && (resp_i != exp_bit);

    // datapath and verdict registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            xidx_q    <= 1'b0;
            xlen_q    <= 2'd0;
            xbits_q   <= 2'b00;
            xexp_q    <= 2'b00;
            h0_q      <= 1'b0;
            sym_cnt_o <= '0;
            done_o    <= 1'b0;
            pass_o    <= 1'b0;
            fail_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_ok) begin
                sym_cnt_o <= '0;
                pass_o    <= 1'b0;
                fail_o    <= 1'b0;
                idx_q     <= '0;
                xidx_q    <= 1'b0;
            end
            if (busy_o) sym_cnt_o <= sym_cnt_o + 1'b1;
            if (mismatch) fail_o <= 1'b1;
            unique case (state_q)
                C_HOME0: h0_q <= resp_i;
                C_HOME1: begin
                    xlen_q  <= plan_len;
                    xbits_q <= plan_bits;
                    xexp_q  <= plan_exp;
                    xidx_q  <= 1'b0;
                end
                C_XFER: xidx_q <= ~xidx_q;
                C_CHECK: begin
                    if (last_chk) begin
                        idx_q  <= '0;
                        done_o <= 1'b1;
                        pass_o <= !(fail_o || mismatch);
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R2: homing starts with 0 then 1
    a_r2_home_order: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> (busy_o && !stim_o))
        else $error("R2 homing order");
    a_r2_home_second: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == C_HOME0) |=> stim_o)
        else $error("R2 second homing symbol");
    // R5: fail holds until an accepted start
    a_r5_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !start_ok) |=> fail_o)
        else $error("R5 fail lapsed");
    // R6: single-cycle done with a single verdict
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o)
        else $error("R6 done longer than one cycle");
    a_r6_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pass_o ^ fail_o))
        else $error("R6 verdict");
    // R7: one symbol per busy cycle
    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (sym_cnt_o == $past(sym_cnt_o) + 1'b1))
        else $error("R7 count step");
    // R8: start while busy does not restart
    a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (state_q != C_HOME0))
        else $error("R8 restart while busy");
    // R9: accepted start clears results
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> (busy_o && !pass_o && !fail_o && sym_cnt_o == '0))
        else $error("R9 clear on start");
endmodule

// File: tb/fsm_check_seq_tb.sv
module fsm_check_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       stim_o, resp_i, busy_o, done_o, pass_o, fail_o;
    logic [7:0] sym_cnt_o;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk; // 250 MHz

    fsm_check_seq #(.CNT_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stim_o(stim_o),
        .resp_i(resp_i), .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o),
        .fail_o(fail_o), .sym_cnt_o(sym_cnt_o)
    );

    // machine under test model: kind 0 good, 1 output flipped, 2 next state forced to B
    logic [1:0] mut_q;
    logic [1:0] load_val = 2'd0;
    logic       load = 1'b0;
    logic [1:0] f_kind = 2'd0;
    logic [2:0] f_tr = 3'd0;

    function automatic logic [1:0] gold_next(input logic [1:0] s, input logic x);
        case ({s, x})
            3'b000: return 2'd1; 3'b001: return 2'd3;
            3'b010: return 2'd0; 3'b011: return 2'd2;
            3'b100: return 2'd1; 3'b101: return 2'd3;
            3'b110: return 2'd2; default: return 2'd0;
        endcase
    endfunction
    function automatic logic gold_out(input logic [1:0] s, input logic x);
        case ({s, x})
            3'b000, 3'b001, 3'b101, 3'b110: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    assign resp_i = gold_out(mut_q, stim_o) ^ (f_kind == 2'd1 && {mut_q, stim_o} == f_tr);

    always @(posedge clk) begin
        if (load) mut_q <= load_val;
        else if (busy_o)
            mut_q <= (f_kind == 2'd2 && {mut_q, stim_o} == f_tr) ? 2'd1 : gold_next(mut_q, stim_o);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    logic stim_log [0:63];
    int   run_len;
    bit   got_done;

    task automatic run_exp(input logic [1:0] s, input logic [1:0] kind, input logic [2:0] tr,
                           input int bump_at);
        int n;
        @(negedge clk);
        f_kind = kind; f_tr = tr; load_val = s; load = 1'b1; start_i = 1'b1;
        @(negedge clk);
        load = 1'b0; start_i = 1'b0;
        n = 0; got_done = 0;
        while (!done_o && n < 200) begin
            if (n < 64) stim_log[n] = stim_o;
            start_i = (n == bump_at);
            @(negedge clk);
            n++;
        end
        start_i = 1'b0;
        got_done = done_o;
        run_len = n;
    endtask

    // {start, kind, transition(state*2+input), pass, length (0: not checked)}
    localparam logic [15:0] VEC [14] = '{
        {2'd0, 2'd0, 3'd0, 1'b1, 8'd42},
        {2'd1, 2'd0, 3'd0, 1'b1, 8'd41},
        {2'd2, 2'd0, 3'd0, 1'b1, 8'd42},
        {2'd3, 2'd0, 3'd0, 1'b1, 8'd41},
        {2'd0, 2'd1, 3'd0, 1'b0, 8'd0},
        {2'd0, 2'd1, 3'd1, 1'b0, 8'd0},
        {2'd0, 2'd1, 3'd2, 1'b0, 8'd0},
        {2'd0, 2'd1, 3'd3, 1'b0, 8'd0},
        {2'd0, 2'd1, 3'd4, 1'b0, 8'd0},
        {2'd0, 2'd1, 3'd5, 1'b0, 8'd0},
        {2'd0, 2'd1, 3'd6, 1'b0, 8'd0},
        {2'd0, 2'd1, 3'd7, 1'b0, 8'd0},
        {2'd3, 2'd2, 3'd1, 1'b0, 8'd0},
        {2'd0, 2'd2, 3'd7, 1'b0, 8'd0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        mut_q = 2'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy_o && !done_o && !pass_o && !fail_o && sym_cnt_o == 0, "R1 reset",
              {busy_o, done_o, pass_o, fail_o}, 0);

        for (int i = 0; i < 14; i++) begin
            run_exp(VEC[i][15:14], VEC[i][13:12], VEC[i][11:9], -1);
            check(got_done, "R6 done seen", int'(got_done), 1);
            // R4 R5 R6 verdict
            check(pass_o == VEC[i][8] && fail_o == !VEC[i][8], "R4/R5 verdict row",
                  {pass_o, fail_o}, {VEC[i][8], !VEC[i][8]});
            if (VEC[i][7:0] != 0) begin
                // R7 length for a correct machine
                check(sym_cnt_o == VEC[i][7:0], "R7 length", sym_cnt_o, VEC[i][7:0]);
                check(run_len == VEC[i][7:0], "R7 cycles per symbol", run_len, VEC[i][7:0]);
            end
        end

        // R2 R3: symbols from a start in A (homing 0,1 then transfer 0,0)
        run_exp(2'd0, 2'd0, 3'd0, -1);
        check(stim_log[0] == 0 && stim_log[1] == 1, "R2 homing symbols",
              {stim_log[0], stim_log[1]}, 1);
        check(stim_log[2] == 0 && stim_log[3] == 0, "R3 transfer from C",
              {stim_log[2], stim_log[3]}, 0);
        // R6 done lasts one cycle, verdict holds
        @(negedge clk);
        check(!done_o && pass_o, "R6 single pulse", {done_o, pass_o}, 1);
        // R3 transfer from D is a single 1
        run_exp(2'd1, 2'd0, 3'd0, -1);
        check(stim_log[2] == 1 && sym_cnt_o == 41, "R3 transfer from D", sym_cnt_o, 41);

        // R8 start mid-run is ignored
        run_exp(2'd1, 2'd0, 3'd0, 10);
        check(sym_cnt_o == 41 && run_len == 41 && pass_o, "R8 start while busy", run_len, 41);

        // R5 fail sticky after done
        run_exp(2'd0, 2'd1, 3'd5, -1);
        repeat (5) @(negedge clk);
        check(fail_o && !pass_o, "R5 fail sticky", fail_o, 1);

        // R9 restart clears results
        @(negedge clk);
        load_val = 2'd2; load = 1'b1; start_i = 1'b1; f_kind = 2'd0;
        @(negedge clk);
        load = 1'b0; start_i = 1'b0;
        check(busy_o && !fail_o && !pass_o && sym_cnt_o == 0, "R9 clear on start",
              {busy_o, fail_o, pass_o}, 4);
        while (!done_o) @(negedge clk);
        check(pass_o && sym_cnt_o == 42, "R9 run after restart", sym_cnt_o, 42);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule